// File: doc/BRIEF.md
# Reset-Sampled Debug Mode Controller

This block decides, once per reset, whether the processor may enter background debug mode. It watches an asynchronous active-low breakpoint pin throughout reset. When reset is released, it enables debug capability only if the synchronized pin has been low for long enough. The decision then holds until the next reset. While it holds, the block steers later breakpoint and background requests. With debug enabled, those requests move the core into a debug-active state. With debug disabled, they turn into breakpoint or illegal-instruction exception pulses.

At the same release edge the block captures a vector of active-low configuration pins. Each pin picks a default or an alternate function, and in narrow-bus (8-bit expanded) mode the low byte is forced to default. The block also tags the first bus cycle after reset when the breakpoint pin is still held at that moment.

Top module: `dbg_gate_ctrl`

## Requirements
- R1: While `rst_n` is low, every output is 0 by the next clock edge. This includes clearing `dbg_active`.
- R2: `dbg_enabled` becomes 1 at release if the synchronized pin (two flops) was low at each of the last two clock edges before the release edge. Pin low for 4 reset edges before release qualifies.
- R3: `dbg_enabled` becomes 0 at release if the pin was high or was low too briefly. Pin low for only 3 reset edges before release does not qualify.
- R4: `dbg_enabled` keeps its value until the next reset and is decided again at every release.
- R5: With debug enabled, a falling edge on the synchronized pin or a `bgnd_req` pulse gives a one-cycle `enter_pulse` and sets `dbg_active`. A pin held low gives one request only.
- R6: While `dbg_active` is 1, `bgnd_req` and pin falling edges have no effect. A `resume` pulse clears `dbg_active`. With debug enabled, `bkpt_insn_req` has no effect.
- R7: With debug disabled, a pin falling edge or `bkpt_insn_req` gives a one-cycle `bkpt_exc_pulse`. It never sets `dbg_active`.
- R8: With debug disabled, `bgnd_req` gives a one-cycle `illegal_pulse`.
- R9: `bus_tagged` pulses for the first `bus_start` after release, but only if the synchronized pin is still low then. Later bus starts are never tagged.
- R10: `cfg_alt[i]` is 1 exactly when `cfg_pins_n[i]` was low at release. If `narrow_bus` is 1 at release, bits 7:0 are forced to 0.
- R11: A pin held low across reset release makes no request after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset, synchronous to clk |
| bkpt_pin_n | input | 1 | Asynchronous active-low breakpoint pin |
| bgnd_req | input | 1 | Background-instruction request |
| bkpt_insn_req | input | 1 | Breakpoint-instruction request |
| bus_start | input | 1 | Bus-cycle start strobe |
| resume | input | 1 | Leave debug-active state |
| narrow_bus | input | 1 | 8-bit expanded bus mode |
| cfg_pins_n | input | CFG_W | Active-low reset configuration pins |
| dbg_enabled | output | 1 | Debug capability granted for this reset |
| dbg_active | output | 1 | Core is in debug mode |
| enter_pulse | output | 1 | One-cycle debug-entry pulse |
| bkpt_exc_pulse | output | 1 | One-cycle breakpoint-exception pulse |
| illegal_pulse | output | 1 | One-cycle illegal-instruction pulse |
| bus_tagged | output | 1 | First bus cycle after reset tagged as breakpoint |
| cfg_alt | output | CFG_W | Latched alternate-function selects |

## Verification
The pin is driven low for 3 and then 4 cycles before release. This probes the qualification boundary at the exact edge where the decision flips.

The same pin edges and background and breakpoint-instruction pulses are then applied under both decisions. This shows the routing changes with the latched decision alone.

A pin held low across release, with and without a following bus start, separates the edge-based request path from the one-shot bus tag. Two configuration patterns, with narrow mode off and on, show the low-byte forcing.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  typedef struct packed {
    logic enter;
    logic bkpt_exc;
    logic illegal;
    logic tag;
  } dbg_evt_t;

  // True when a run of synchronized low samples is long enough to qualify.
  function automatic logic run_qualifies(input int unsigned run_len,
                                         input int unsigned need);
    return run_len >= need;
  endfunction
endpackage

// File: rtl/dbg_pin_sync.sv
module dbg_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic pin_n_async,
  output logic pin_low,
  output logic pin_fall
);
  logic [STAGES-1:0] sync_q;
  logic              low_prev_q;

  // Synchronizer is never reset: it must keep sampling during reset.
  always_ff @(posedge clk) begin
    sync_q     <= {sync_q[STAGES-2:0], pin_n_async};
    low_prev_q <= ~sync_q[STAGES-1];
  end

  assign pin_low  = ~sync_q[STAGES-1];
  assign pin_fall = pin_low & ~low_prev_q;
endmodule

// File: rtl/dbg_reset_qual.sv
module dbg_reset_qual
  import dbg_pkg::*;
#(
  parameter int MIN_LOW = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_low,
  output logic rel_evt,
  output logic run,
  output logic qual_en
);
  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] SAT = CW'(MIN_LOW);

  logic [CW-1:0] low_run_q;
  logic          in_reset_q;

  always_ff @(posedge clk) begin
    in_reset_q <= ~rst_n;
    if (!rst_n) begin
      if (!pin_low)
        low_run_q <= '0;
      else if (low_run_q != SAT)
        low_run_q <= low_run_q + 1'b1;
    end else begin
      low_run_q <= '0;
    end
  end

  assign rel_evt = rst_n & in_reset_q;
  assign run     = rst_n & ~in_reset_q;
  assign qual_en = run_qualifies(int'(low_run_q), MIN_LOW);
endmodule

// File: rtl/dbg_cfg_latch.sv
module dbg_cfg_latch #(
  parameter int CFG_W    = 16,
  parameter int NARROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rel_evt,
  input  logic             narrow_bus,
  input  logic [CFG_W-1:0] cfg_pins_n,
  output logic [CFG_W-1:0] cfg_alt
);
  localparam logic [CFG_W-1:0] LOW_MASK = CFG_W'((1 << NARROW_W) - 1);

  function automatic logic [CFG_W-1:0] decode_cfg(input logic [CFG_W-1:0] pins_n,
                                                  input logic narrow);
    logic [CFG_W-1:0] alt;
    alt = ~pins_n;
    if (narrow) alt = alt & ~LOW_MASK;
    return alt;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)
      cfg_alt <= '0;
    else if (rel_evt)
      cfg_alt <= decode_cfg(cfg_pins_n, narrow_bus);
  end
endmodule

// File: rtl/dbg_req_router.sv
module dbg_req_router
  import dbg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  logic     rel_evt,
  input  logic     qual_en,
  input  logic     pin_low,
  input  logic     pin_fall,
  input  logic     bgnd_req,
  input  logic     bkpt_insn_req,
  input  logic     bus_start,
  input  logic     resume,
  output logic     dbg_enabled,
  output logic     dbg_active,
  output dbg_evt_t evt_q
);
  dbg_evt_t evt_d;
  logic     tag_armed_q;

  always_comb begin
    evt_d          = '0;
    evt_d.enter    = run & dbg_enabled & ~dbg_active & (pin_fall | bgnd_req);
    evt_d.bkpt_exc = run & ~dbg_enabled & (pin_fall | bkpt_insn_req);
    evt_d.illegal  = run & ~dbg_enabled & bgnd_req;
    evt_d.tag      = run & tag_armed_q & bus_start & pin_low;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dbg_enabled <= 1'b0;
      dbg_active  <= 1'b0;
      tag_armed_q <= 1'b0;
      evt_q       <= '0;
    end else begin
      evt_q <= evt_d;
      if (rel_evt) begin
        dbg_enabled <= qual_en;
        tag_armed_q <= 1'b1;
      end else if (run && bus_start) begin
        tag_armed_q <= 1'b0;
      end
      if (evt_d.enter)
        dbg_active <= 1'b1;
      else if (run && resume)
        dbg_active <= 1'b0;
    end
  end
endmodule

// File: rtl/dbg_gate_ctrl.sv
module dbg_gate_ctrl
  import dbg_pkg::*;
#(
  parameter int CFG_W       = 16,
  parameter int NARROW_W    = 8,
  parameter int MIN_LOW     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bkpt_pin_n,
  input  logic             bgnd_req,
  input  logic             bkpt_insn_req,
  input  logic             bus_start,
  input  logic             resume,
  input  logic             narrow_bus,
  input  logic [CFG_W-1:0] cfg_pins_n,
  output logic             dbg_enabled,
  output logic             dbg_active,
  output logic             enter_pulse,
  output logic             bkpt_exc_pulse,
  output logic             illegal_pulse,
  output logic             bus_tagged,
  output logic [CFG_W-1:0] cfg_alt
);
  // Named internal events, visible to the bound checker.
  logic     pin_low_w;
  logic     pin_fall_w;
  logic     rel_evt;
  logic     run_w;
  logic     qual_en_w;
  dbg_evt_t evt_w;

  dbg_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk         (clk),
    .pin_n_async (bkpt_pin_n),
    .pin_low     (pin_low_w),
    .pin_fall    (pin_fall_w)
  );

  dbg_reset_qual #(.MIN_LOW(MIN_LOW)) qual_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_low (pin_low_w),
    .rel_evt (rel_evt),
    .run     (run_w),
    .qual_en (qual_en_w)
  );

  dbg_cfg_latch #(.CFG_W(CFG_W), .NARROW_W(NARROW_W)) cfg_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rel_evt    (rel_evt),
    .narrow_bus (narrow_bus),
    .cfg_pins_n (cfg_pins_n),
    .cfg_alt    (cfg_alt)
  );

  dbg_req_router route_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .run           (run_w),
    .rel_evt       (rel_evt),
    .qual_en       (qual_en_w),
    .pin_low       (pin_low_w),
    .pin_fall      (pin_fall_w),
    .bgnd_req      (bgnd_req),
    .bkpt_insn_req (bkpt_insn_req),
    .bus_start     (bus_start),
    .resume        (resume),
    .dbg_enabled   (dbg_enabled),
    .dbg_active    (dbg_active),
    .evt_q         (evt_w)
  );

  assign enter_pulse    = evt_w.enter;
  assign bkpt_exc_pulse = evt_w.bkpt_exc;
  assign illegal_pulse  = evt_w.illegal;
  assign bus_tagged     = evt_w.tag;
endmodule

// File: rtl/dbg_gate_ctrl_chk.sv
module dbg_gate_ctrl_chk #(
  parameter int CFG_W    = 16,
  parameter int NARROW_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             narrow_bus,
  input logic             rel_evt,
  input logic             dbg_enabled,
  input logic             dbg_active,
  input logic             enter_pulse,
  input logic             bkpt_exc_pulse,
  input logic             illegal_pulse,
  input logic             bus_tagged,
  input logic [CFG_W-1:0] cfg_alt
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!dbg_active && !dbg_enabled && !enter_pulse && !bkpt_exc_pulse
                && !illegal_pulse && !bus_tagged && cfg_alt == '0));

  a_r4_decision_held: assert property (@(posedge clk) disable iff (!rst_n)
    !rel_evt |=> $stable(dbg_enabled));

  a_r5_enter_sets_active: assert property (@(posedge clk) disable iff (!rst_n)
    enter_pulse |-> dbg_active);

  a_r6_enter_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    enter_pulse |-> !$past(dbg_active));

  a_r7_exc_only_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    bkpt_exc_pulse |-> !dbg_enabled && !dbg_active);

  a_r8_illegal_only_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_pulse |-> !dbg_enabled);

  a_r10_narrow_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_evt && narrow_bus) |=> cfg_alt[NARROW_W-1:0] == '0);
endmodule

bind dbg_gate_ctrl dbg_gate_ctrl_chk #(.CFG_W(CFG_W), .NARROW_W(NARROW_W)) chk_i (.*);

// File: tb/dbg_gate_ctrl_tb.sv
module dbg_gate_ctrl_tb_top;
  localparam int PERIOD = 10;
  localparam int CFG_W  = 16;

  logic clk = 1'b0;
  logic rst_n, bkpt_pin_n, bgnd_req, bkpt_insn_req, bus_start, resume, narrow_bus;
  logic [CFG_W-1:0] cfg_pins_n;
  logic dbg_enabled, dbg_active, enter_pulse, bkpt_exc_pulse, illegal_pulse, bus_tagged;
  logic [CFG_W-1:0] cfg_alt;
  int n_vec = 0;
  int n_bad = 0;

  always #(PERIOD/2) clk = ~clk;

  dbg_gate_ctrl #(.CFG_W(CFG_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bkpt_pin_n(bkpt_pin_n), .bgnd_req(bgnd_req),
    .bkpt_insn_req(bkpt_insn_req), .bus_start(bus_start), .resume(resume),
    .narrow_bus(narrow_bus), .cfg_pins_n(cfg_pins_n), .dbg_enabled(dbg_enabled),
    .dbg_active(dbg_active), .enter_pulse(enter_pulse), .bkpt_exc_pulse(bkpt_exc_pulse),
    .illegal_pulse(illegal_pulse), .bus_tagged(bus_tagged), .cfg_alt(cfg_alt)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [6:0] pulses();
    return {dbg_active, enter_pulse, bkpt_exc_pulse, illegal_pulse, bus_tagged, dbg_enabled, 1'b0};
  endfunction

  // Reset with the pin low for low_edges reset edges before the release edge.
  task automatic do_reset(input int low_edges, input logic narrow, input logic [CFG_W-1:0] pins);
    @(negedge clk);
    rst_n = 1'b0; bkpt_pin_n = 1'b1; narrow_bus = narrow; cfg_pins_n = pins;
    repeat (6) @(posedge clk);
    @(negedge clk);
    if (low_edges > 0) bkpt_pin_n = 1'b0;
    repeat (low_edges) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_in(input int which);
    @(negedge clk);
    case (which)
      0: bgnd_req = 1'b1;
      1: bkpt_insn_req = 1'b1;
      2: bus_start = 1'b1;
      default: resume = 1'b1;
    endcase
    @(negedge clk);
    bgnd_req = 1'b0; bkpt_insn_req = 1'b0; bus_start = 1'b0; resume = 1'b0;
  endtask

  task automatic pin_fall_in();
    @(negedge clk); bkpt_pin_n = 1'b1;
    repeat (4) @(negedge clk);
    bkpt_pin_n = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 outputs in reset", {25'd0, pulses()}, 32'd0);
    chk("R1 cfg_alt in reset", {16'd0, cfg_alt}, 32'd0);
  endtask

  task automatic t_qual_boundary();
    do_reset(3, 1'b0, '1);
    chk("R3 three-edge low not enough", {31'd0, dbg_enabled}, 32'd0);
    do_reset(0, 1'b0, '1);
    chk("R3 pin high disables", {31'd0, dbg_enabled}, 32'd0);
    do_reset(4, 1'b0, '1);
    chk("R2 four-edge low enables", {31'd0, dbg_enabled}, 32'd1);
  endtask

  task automatic t_enabled_routing();
    do_reset(4, 1'b0, '1);
    repeat (4) @(negedge clk);
    chk("R11 held pin no request", {31'd0, dbg_active}, 32'd0);
    pulse_in(2);
    chk("R9 first bus start tagged", {31'd0, bus_tagged}, 32'd1);
    pulse_in(2);
    chk("R9 second bus start untagged", {31'd0, bus_tagged}, 32'd0);
    pin_fall_in();
    chk("R5 pin edge enters", {30'd0, enter_pulse, dbg_active}, 32'd3);
    repeat (3) @(negedge clk);
    chk("R5 held pin single request", {31'd0, enter_pulse}, 32'd0);
    pulse_in(0);
    chk("R6 bgnd ignored when active", {29'd0, enter_pulse, illegal_pulse, dbg_active}, 32'd1);
    pulse_in(3);
    chk("R6 resume clears active", {31'd0, dbg_active}, 32'd0);
    pulse_in(1);
    chk("R6 bkpt insn ignored when enabled", {28'd0, enter_pulse, bkpt_exc_pulse, dbg_active, illegal_pulse}, 32'd0);
    pulse_in(0);
    chk("R5 bgnd enters", {30'd0, enter_pulse, dbg_active}, 32'd3);
    @(negedge clk);
    chk("R5 enter pulse one cycle", {31'd0, enter_pulse}, 32'd0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears active", {31'd0, dbg_active}, 32'd0);
  endtask

  task automatic t_disabled_routing();
    do_reset(0, 1'b0, '1);
    pulse_in(2);
    chk("R9 no tag with pin high", {31'd0, bus_tagged}, 32'd0);
    pulse_in(1);
    chk("R7 bkpt insn gives exception", {30'd0, bkpt_exc_pulse, dbg_active}, 32'd2);
    @(negedge clk);
    chk("R7 exception pulse one cycle", {31'd0, bkpt_exc_pulse}, 32'd0);
    pin_fall_in();
    chk("R7 pin edge gives exception", {29'd0, bkpt_exc_pulse, enter_pulse, dbg_active}, 32'd4);
    pulse_in(0);
    chk("R8 bgnd gives illegal", {29'd0, illegal_pulse, enter_pulse, dbg_active}, 32'd4);
    repeat (20) @(negedge clk);
    chk("R4 decision held", {31'd0, dbg_enabled}, 32'd0);
    do_reset(5, 1'b0, '1);
    chk("R4 relatched on next release", {31'd0, dbg_enabled}, 32'd1);
  endtask

  task automatic t_cfg();
    do_reset(0, 1'b0, 16'hA53C);
    chk("R10 alternate bits", {16'd0, cfg_alt}, 32'h5AC3);
    cfg_pins_n = 16'h0000;
    repeat (3) @(negedge clk);
    chk("R10 held after release", {16'd0, cfg_alt}, 32'h5AC3);
    do_reset(0, 1'b1, 16'hA53C);
    chk("R10 narrow forces low byte", {16'd0, cfg_alt}, 32'h5A00);
  endtask

  initial begin
    #(PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bkpt_pin_n = 1'b1; bgnd_req = 1'b0; bkpt_insn_req = 1'b0;
    bus_start = 1'b0; resume = 1'b0; narrow_bus = 1'b0; cfg_pins_n = '1;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_qual_boundary();
    t_enabled_routing();
    t_disabled_routing();
    t_cfg();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule